// File: doc/BRIEF.md
# Three-Wire Serial Tuning Word Receiver

This block takes a tuning word from a host over a simple three-line serial link (bit clock, data and a frame enable) and turns it into the divider and reference settings of a frequency synthesizer. The host has no length field to program. The receiver counts the bits clocked in during one enable window and works out the frame type from that count. When enable falls, the frame is accepted only if it held 18, 19 or 27 bits. An accepted frame loads the main ratio, the swallow count, the band outputs and the reference divide. A 27-bit frame also loads the loop control flags.

The link is not a stream, so it has no valid/ready handshake. The host cannot be stalled, and every accepted frame replaces the previous settings at once. The three line inputs are asynchronous to the block clock and pass through a synchronizer. Bit edges are found by oversampling, so the serial clock must stay well below the block clock. A static strap input, `mode_high`, tells the block whether the mode pin is tied high (1) or left open (0). Together with the frame length, this strap picks the reference divide for the two short frame types. The resulting comparison steps are 62.5, 50 and 31.25 kHz when the reference crystal is 4 MHz.

Top module: `tw_len_rx`

## Requirements
- R1: After reset, main_ratio, swallow, band_en, cp_boost, cp_off, vt_off and commit are 0 and ref_ratio is 64.
- R2: A data bit is taken on each rising edge of ser_clk while ser_en is high, with the first bit taken being the MSB of the frame. Edges of ser_clk while ser_en is low have no effect on any output.
- R3: An 18-bit frame is, from first bit to last, a 9-bit main ratio, a 5-bit swallow count and a 4-bit band field. main_ratio bit 9 reads 0 after it.
- R4: A 19-bit frame is, from first bit to last, a 10-bit main ratio, a 5-bit swallow count and a 4-bit band field.
- R5: A 27-bit frame is, from first bit to last, a 10-bit main ratio, a 5-bit swallow count, an 8-bit control byte and a 4-bit band field. In the control byte (bit 7 sent first), bit 6 sets cp_boost, bit 4 sets cp_off, bit 0 sets vt_off, and bits 7, 5 and 3 are ignored. 18- and 19-bit frames leave cp_boost, cp_off and vt_off unchanged.
- R6: With mode_high=0, an 18-bit frame sets ref_ratio to 64 and a 19-bit frame sets it to 128.
- R7: With mode_high=1, both 18-bit and 19-bit frames set ref_ratio to 80.
- R8: In a 27-bit frame, control bits {2,1} pick ref_ratio: bit 1 = 0 gives 80, {0,1} gives 128, {1,1} gives 64, whatever mode_high is. ref_ratio only ever holds 64, 80 or 128.
- R9: A frame of any other bit count, including very long frames, changes no output and raises no commit.
- R10: commit is a single-cycle pulse raised once for each accepted frame, in the same cycle the new settings appear. Outputs do not change in any cycle without commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_clk | input | 1 | Serial bit clock (asynchronous) |
| ser_data | input | 1 | Serial data (asynchronous) |
| ser_en | input | 1 | Frame enable, high during a frame (asynchronous) |
| mode_high | input | 1 | Mode strap: 1 = tied high, 0 = open |
| main_ratio | output | 10 | Main divider ratio |
| swallow | output | 5 | Swallow counter ratio |
| band_en | output | 4 | Band switch enables |
| ref_ratio | output | 8 | Reference divide (64, 80 or 128) |
| cp_boost | output | 1 | High charge-pump current select |
| cp_off | output | 1 | Charge pump disable |
| vt_off | output | 1 | Tuning voltage output disable |
| commit | output | 1 | One-cycle pulse when a frame is accepted |

## Verification
Frames of each legal length are sent under both strap settings. Pairs of frames that share a length but differ only in the strap, or share a strap but differ in length, show whether the reference choice really depends on both inputs. Long frames are sent with the three reference codes and with the ignored control bits set, which separates decoded fields from ignored ones. A control-carrying frame followed by a short one shows that the control flags are retained. Near-miss lengths (17, 20, 26, 28) and an overlong frame, plus serial clocks sent outside the enable window, must all leave the outputs and the commit count untouched.

// File: rtl/tw_pkg.sv
package tw_pkg;
  localparam int unsigned REF_W = 8;
  localparam logic [REF_W-1:0] DIV_FINE   = 8'd128;
  localparam logic [REF_W-1:0] DIV_MID    = 8'd80;
  localparam logic [REF_W-1:0] DIV_COARSE = 8'd64;

  typedef enum logic [1:0] {
    LEN_BAD   = 2'd0,
    LEN_SHORT = 2'd1,
    LEN_MID   = 2'd2,
    LEN_LONG  = 2'd3
  } frame_len_t;

  // reference pick from the two control code bits {hi, lo}
  function automatic logic [REF_W-1:0] ref_from_code(input logic hi, input logic lo);
    if (!lo)     return DIV_MID;
    else if (hi) return DIV_COARSE;
    else         return DIV_FINE;
  endfunction
endpackage

// File: rtl/tw_sync_edge.sv
module tw_sync_edge #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] lvl,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [W-1:0] pipe [STAGES];
  logic [W-1:0] prev;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) pipe[0] <= '0;
          else        pipe[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) pipe[g] <= '0;
          else        pipe[g] <= pipe[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) prev <= '0;
    else        prev <= pipe[STAGES-1];
  end

  assign lvl  = pipe[STAGES-1];
  assign rise = lvl & ~prev;
  assign fall = ~lvl & prev;
endmodule

// File: rtl/tw_shifter.sv
module tw_shifter #(
  parameter int unsigned SR_W  = 27,
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_lvl,
  input  logic             en_rise,
  input  logic             bit_rise,
  input  logic             din,
  output logic [SR_W-1:0]  shreg,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg <= '0;
      cnt   <= '0;
    end else if (en_rise) begin
      cnt <= '0;
    end else if (bit_rise && en_lvl) begin
      shreg <= {shreg[SR_W-2:0], din};
      if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
    end
  end

  AST_CNT_NO_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(en_rise) |-> cnt >= $past(cnt)); // R2
  AST_CNT_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(en_lvl) |-> $stable(cnt) && $stable(shreg)); // R2
endmodule

// File: rtl/tw_frame_decode.sv
module tw_frame_decode
  import tw_pkg::*;
#(
  parameter int unsigned M_W    = 10,
  parameter int unsigned S_W    = 5,
  parameter int unsigned BAND_W = 4,
  parameter int unsigned CTRL_W = 8,
  parameter int unsigned SR_W   = 27,
  parameter int unsigned CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_fall,
  input  logic              mode_high,
  input  logic [SR_W-1:0]   shreg,
  input  logic [CNT_W-1:0]  cnt,
  output logic [M_W-1:0]    main_ratio,
  output logic [S_W-1:0]    swallow,
  output logic [BAND_W-1:0] band_en,
  output logic [REF_W-1:0]  ref_ratio,
  output logic              cp_boost,
  output logic              cp_off,
  output logic              vt_off,
  output logic              commit
);
  localparam int unsigned N_SHORT = (M_W - 1) + S_W + BAND_W;
  localparam int unsigned N_MID   = M_W + S_W + BAND_W;
  localparam int unsigned N_LONG  = N_MID + CTRL_W;
  localparam int unsigned S_LO_SM = BAND_W;              // swallow LSB, short/mid
  localparam int unsigned M_LO_SM = BAND_W + S_W;        // main LSB, short/mid
  localparam int unsigned C_LO    = BAND_W;              // control LSB, long
  localparam int unsigned S_LO_L  = BAND_W + CTRL_W;     // swallow LSB, long
  localparam int unsigned M_LO_L  = BAND_W + CTRL_W + S_W;

  frame_len_t        len;
  logic [M_W-1:0]    m_nx;
  logic [S_W-1:0]    s_nx;
  logic [BAND_W-1:0] b_nx;
  logic [REF_W-1:0]  r_nx;
  logic              boost_nx, off_nx, vt_nx;

  always_comb begin
    if      (cnt == CNT_W'(N_SHORT)) len = LEN_SHORT;
    else if (cnt == CNT_W'(N_MID))   len = LEN_MID;
    else if (cnt == CNT_W'(N_LONG))  len = LEN_LONG;
    else                             len = LEN_BAD;
  end

  always_comb begin
    m_nx     = main_ratio;
    s_nx     = swallow;
    b_nx     = band_en;
    r_nx     = ref_ratio;
    boost_nx = cp_boost;
    off_nx   = cp_off;
    vt_nx    = vt_off;
    case (len)
      LEN_SHORT: begin
        m_nx = {1'b0, shreg[M_LO_SM +: M_W-1]};
        s_nx = shreg[S_LO_SM +: S_W];
        b_nx = shreg[0 +: BAND_W];
        r_nx = mode_high ? DIV_MID : DIV_COARSE;
      end
      LEN_MID: begin
        m_nx = shreg[M_LO_SM +: M_W];
        s_nx = shreg[S_LO_SM +: S_W];
        b_nx = shreg[0 +: BAND_W];
        r_nx = mode_high ? DIV_MID : DIV_FINE;
      end
      LEN_LONG: begin
        m_nx     = shreg[M_LO_L +: M_W];
        s_nx     = shreg[S_LO_L +: S_W];
        b_nx     = shreg[0 +: BAND_W];
        boost_nx = shreg[C_LO + 6];
        off_nx   = shreg[C_LO + 4];
        vt_nx    = shreg[C_LO + 0];
        r_nx     = ref_from_code(shreg[C_LO + 2], shreg[C_LO + 1]);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      main_ratio <= '0;
      swallow    <= '0;
      band_en    <= '0;
      ref_ratio  <= DIV_COARSE;
      cp_boost   <= 1'b0;
      cp_off     <= 1'b0;
      vt_off     <= 1'b0;
      commit     <= 1'b0;
    end else begin
      commit <= 1'b0;
      if (en_fall && (len != LEN_BAD)) begin
        main_ratio <= m_nx;
        swallow    <= s_nx;
        band_en    <= b_nx;
        ref_ratio  <= r_nx;
        cp_boost   <= boost_nx;
        cp_off     <= off_nx;
        vt_off     <= vt_nx;
        commit     <= 1'b1;
      end
    end
  end

  AST_COMMIT_LEGAL_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> $past(en_fall) && ($past(cnt) == CNT_W'(N_SHORT) ||
      $past(cnt) == CNT_W'(N_MID) || $past(cnt) == CNT_W'(N_LONG))); // R9
  AST_HOLD_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |-> $stable(main_ratio) && $stable(swallow) && $stable(band_en) &&
      $stable(ref_ratio) && $stable(cp_boost) && $stable(cp_off) && $stable(vt_off)); // R10
  AST_COMMIT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !commit); // R10
  AST_REF_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    ref_ratio == DIV_COARSE || ref_ratio == DIV_MID || ref_ratio == DIV_FINE); // R8
  AST_SHORT_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    commit && $past(cnt) == CNT_W'(N_SHORT) |-> !main_ratio[M_W-1]); // R3
endmodule

// File: rtl/tw_len_rx.sv
module tw_len_rx
  import tw_pkg::*;
#(
  parameter int unsigned M_W         = 10,
  parameter int unsigned S_W         = 5,
  parameter int unsigned BAND_W      = 4,
  parameter int unsigned CTRL_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk,
  input  logic              ser_data,
  input  logic              ser_en,
  input  logic              mode_high,
  output logic [M_W-1:0]    main_ratio,
  output logic [S_W-1:0]    swallow,
  output logic [BAND_W-1:0] band_en,
  output logic [REF_W-1:0]  ref_ratio,
  output logic              cp_boost,
  output logic              cp_off,
  output logic              vt_off,
  output logic              commit
);
  localparam int unsigned SR_W  = M_W + S_W + CTRL_W + BAND_W;
  localparam int unsigned CNT_W = $clog2(SR_W + 2);

  logic [2:0] lvl, rise, fall;
  logic [SR_W-1:0]  shreg;
  logic [CNT_W-1:0] cnt;

  // lane 0 = bit clock, 1 = data, 2 = enable
  tw_sync_edge #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({ser_en, ser_data, ser_clk}),
    .lvl  (lvl),
    .rise (rise),
    .fall (fall)
  );

  tw_shifter #(.SR_W(SR_W), .CNT_W(CNT_W)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_lvl  (lvl[2]),
    .en_rise (rise[2]),
    .bit_rise(rise[0]),
    .din     (lvl[1]),
    .shreg   (shreg),
    .cnt     (cnt)
  );

  tw_frame_decode #(
    .M_W(M_W), .S_W(S_W), .BAND_W(BAND_W), .CTRL_W(CTRL_W),
    .SR_W(SR_W), .CNT_W(CNT_W)
  ) u_dec (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_fall   (fall[2]),
    .mode_high (mode_high),
    .shreg     (shreg),
    .cnt       (cnt),
    .main_ratio(main_ratio),
    .swallow   (swallow),
    .band_en   (band_en),
    .ref_ratio (ref_ratio),
    .cp_boost  (cp_boost),
    .cp_off    (cp_off),
    .vt_off    (vt_off),
    .commit    (commit)
  );

  // the lane-1 edge outputs and lane-0 level/fall feed nothing on purpose
  logic unused_lanes;
  assign unused_lanes = ^{rise[1], fall[1:0], lvl[0]};
endmodule

// File: tb/sim_tw_len_rx.sv
`timescale 1ns/1ps
module sim_tw_len_rx;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_data = 1'b0, ser_en = 1'b0, mode_high = 1'b0;
  logic [9:0] main_ratio;
  logic [4:0] swallow;
  logic [3:0] band_en;
  logic [7:0] ref_ratio;
  logic cp_boost, cp_off, vt_off, commit;

  int checks = 0;
  int errors = 0;
  int ncommit = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  tw_len_rx u0 (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
    .ser_en(ser_en), .mode_high(mode_high), .main_ratio(main_ratio),
    .swallow(swallow), .band_en(band_en), .ref_ratio(ref_ratio),
    .cp_boost(cp_boost), .cp_off(cp_off), .vt_off(vt_off), .commit(commit)
  );

  always @(negedge clk) if (rst_n && commit) ncommit++;

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_frame(input logic [63:0] bits, input int n);
    ser_en = 1'b1;
    wait_cyc(8);
    for (int i = n - 1; i >= 0; i--) begin
      ser_data = bits[i];
      wait_cyc(4);
      ser_clk = 1'b1;
      wait_cyc(8);
      ser_clk = 1'b0;
      wait_cyc(4);
    end
    ser_en = 1'b0;
    wait_cyc(12);
  endtask

  function automatic logic [63:0] f18(logic [8:0] m, logic [4:0] s, logic [3:0] b);
    return {45'd0, m, s, b};
  endfunction
  function automatic logic [63:0] f19(logic [9:0] m, logic [4:0] s, logic [3:0] b);
    return {45'd0, m, s, b};
  endfunction
  function automatic logic [63:0] f27(logic [9:0] m, logic [4:0] s, logic [7:0] c, logic [3:0] b);
    return {37'd0, m, s, c, b};
  endfunction

  task automatic t_reset;
    chk("R1 main", 32'(main_ratio), 0);
    chk("R1 swallow", 32'(swallow), 0);
    chk("R1 band", 32'(band_en), 0);
    chk("R1 ref", 32'(ref_ratio), 64);
    chk("R1 ctrl", {29'd0, cp_boost, cp_off, vt_off}, 0);
    chk("R1 commit", 32'(commit), 0);
  endtask

  task automatic t_short_open;
    int c0 = ncommit;
    mode_high = 1'b0;
    send_frame(f18(9'h1A5, 5'd17, 4'hA), 18);
    chk("R3 main", 32'(main_ratio), 32'h1A5);
    chk("R3 swallow", 32'(swallow), 17);
    chk("R3 band", 32'(band_en), 32'hA);
    chk("R6 ref18 open", 32'(ref_ratio), 64);
    chk("R10 one commit", 32'(ncommit - c0), 1);
  endtask

  task automatic t_mid_open;
    mode_high = 1'b0;
    send_frame(f19(10'h3C7, 5'd3, 4'h5), 19);
    chk("R4 main", 32'(main_ratio), 32'h3C7);
    chk("R4 swallow", 32'(swallow), 3);
    chk("R4 band", 32'(band_en), 5);
    chk("R6 ref19 open", 32'(ref_ratio), 128);
  endtask

  task automatic t_strap_high;
    mode_high = 1'b1;
    send_frame(f18(9'h0F0, 5'd1, 4'h1), 18);
    chk("R7 ref18 high", 32'(ref_ratio), 80);
    chk("R3 main high", 32'(main_ratio), 32'h0F0);
    send_frame(f19(10'h201, 5'd30, 4'h8), 19);
    chk("R7 ref19 high", 32'(ref_ratio), 80);
    chk("R4 main high", 32'(main_ratio), 32'h201);
    chk("R4 swallow high", 32'(swallow), 30);
    mode_high = 1'b0;
  endtask

  task automatic t_long_frames;
    mode_high = 1'b0;
    send_frame(f27(10'h2AB, 5'h1F, 8'b1101_0011, 4'hC), 27);
    chk("R5 main", 32'(main_ratio), 32'h2AB);
    chk("R5 swallow", 32'(swallow), 32'h1F);
    chk("R5 band", 32'(band_en), 32'hC);
    chk("R5 ctrl", {29'd0, cp_boost, cp_off, vt_off}, 3'b111);
    chk("R8 code01", 32'(ref_ratio), 128);
    mode_high = 1'b1;
    send_frame(f27(10'h155, 5'd0, 8'b1000_0110, 4'h3), 27);
    chk("R8 code11 strap high", 32'(ref_ratio), 64);
    chk("R5 ctrl clear", {29'd0, cp_boost, cp_off, vt_off}, 0);
    chk("R5 main2", 32'(main_ratio), 32'h155);
    mode_high = 1'b0;
    send_frame(f27(10'h001, 5'd9, 8'b1010_1000, 4'h6), 27);
    chk("R8 code00", 32'(ref_ratio), 80);
    chk("R5 ignored bits", {29'd0, cp_boost, cp_off, vt_off}, 0);
  endtask

  task automatic t_ctrl_retained;
    send_frame(f27(10'h0AA, 5'd2, 8'b1101_0001, 4'h0), 27);
    chk("R8 code00b", 32'(ref_ratio), 80);
    send_frame(f19(10'h321, 5'd4, 4'h9), 19);
    chk("R5 ctrl kept", {29'd0, cp_boost, cp_off, vt_off}, 3'b111);
    chk("R6 ref19 after long", 32'(ref_ratio), 128);
    chk("R4 main after long", 32'(main_ratio), 32'h321);
  endtask

  task automatic t_bad_lengths;
    logic [9:0] m0 = main_ratio;
    logic [7:0] r0 = ref_ratio;
    logic [3:0] b0 = band_en;
    int c0 = ncommit;
    int lens[5] = '{17, 20, 26, 28, 40};
    foreach (lens[k]) begin
      send_frame({64{1'b1}}, lens[k]);
      chk("R9 main", 32'(main_ratio), 32'(m0));
      chk("R9 ref", 32'(ref_ratio), 32'(r0));
      chk("R9 band", 32'(band_en), 32'(b0));
      chk("R9 no commit", 32'(ncommit - c0), 0);
    end
  endtask

  task automatic t_stray_clocks;
    logic [9:0] m0 = main_ratio;
    int c0 = ncommit;
    ser_data = 1'b1;
    for (int i = 0; i < 5; i++) begin
      ser_clk = 1'b1; wait_cyc(8);
      ser_clk = 1'b0; wait_cyc(8);
    end
    chk("R2 idle main", 32'(main_ratio), 32'(m0));
    chk("R2 idle commit", 32'(ncommit - c0), 0);
    send_frame(f18(9'h003, 5'd31, 4'hF), 18);
    chk("R2 main after stray", 32'(main_ratio), 3);
    chk("R2 swallow after stray", 32'(swallow), 31);
    chk("R10 commit after stray", 32'(ncommit - c0), 1);
  endtask

  initial begin
    wait_cyc(5);
    rst_n = 1'b1;
    wait_cyc(3);
    t_reset();
    t_short_open();
    t_mid_open();
    t_strap_high();
    t_long_frames();
    t_ctrl_retained();
    t_bad_lengths();
    t_stray_clocks();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule